// File: doc/BRIEF.md
# Frame-to-Word Gearbox

This block connects a wide frame interface to a narrow serial-side word interface. Two clocks drive it, and both come from one source: a frame clock, and a word clock that runs exactly six times faster with its rising edges aligned to the frame clock. The frame on each side is 120 bits. Upstream logic has already packed the 84-bit user payload, header and parity into it. The serial-side word is 20 bits.

On the transmit side, the block writes one frame into a two-slot buffer on every frame clock edge. On the word clock it sends that frame out as six consecutive words. On the receive side, it gathers six consecutive words into the buffer. Once a full group is complete, the frame clock domain presents the group as one frame and raises a valid strobe.

Each clock domain has a synchronous active-high reset. After reset, the first frame-clock edge with reset low sets the frame phase that both directions use from then on.

Top module: `frame_word_gearbox`

In the requirements, frame edge 0 is the first rising frame-clock edge with both resets low. Word edges are counted from that same instant, so word edge 0 coincides with frame edge 0 and word edge 6n coincides with frame edge n.

## Requirements
- R1: While both resets are held, tx_word_o, rx_frame_o and rx_valid_o read zero. tx_word_o stays zero until word edge 1.
- R2: Word j of a frame (j = 0..5) carries frame bits [20j+19:20j]. Word 0 is sent first.
- R3: The frame sampled on tx_frame_i at frame edge n is driven on tx_word_o as word j from word edge 6n+1+j until the next word edge.
- R4: Every frame edge takes in a new transmit frame. The word stream has no gap, no skipped frame and no repeated frame across back-to-back frames.
- R5: The rx_word_i value sampled at word edge 6n+1+j becomes bits [20j+19:20j] of receive group n.
- R6: Receive group n appears on rx_frame_o from frame edge n+2 and is held for one frame period.
- R7: rx_valid_o is low after frame edges 0 and 1. After every later frame edge it is high for that frame period, one strobe per assembled group.
- R8: The rx_word_i value sampled at word edge 0 is not captured into any group.
- R9: Asserting both resets in the middle of a frame, for at least one frame period, restarts both directions. R1 to R8 then apply again, counted from the new frame edge 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_frame_i | input | 1 | Frame clock, one sixth of the word clock, rising edges aligned with it |
| rst_frame_i | input | 1 | Synchronous active-high reset, frame domain |
| clk_word_i | input | 1 | Word clock |
| rst_word_i | input | 1 | Synchronous active-high reset, word domain |
| tx_frame_i | input | 120 | Transmit frame, sampled on every frame clock edge |
| tx_word_o | output | 20 | Transmit word, one per word clock |
| rx_word_i | input | 20 | Receive word, sampled on every word clock edge |
| rx_frame_o | output | 120 | Assembled receive frame |
| rx_valid_o | output | 1 | High for one frame clock for each assembled group |

## Verification
The transmit word for frame n, position j, is due on the word edge 6n+1+j, one register after the frame write. The receive group gathered during frame period n is due on frame edge n+2, because its last word lands on frame edge n+1.

The bench counts word edges from reset release and keeps queues of what it drove at each edge. It samples the outputs on the falling word-clock edge after every rising one, so each expected value is looked up by edge number and not by elapsed time. Three stimulus styles are used (random, counting, alternating), and a mid-frame reset restarts the edge count.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    localparam int unsigned WORD_W          = 20;
    localparam int unsigned WORDS_PER_FRAME = 6;
    localparam int unsigned FRAME_W         = WORD_W * WORDS_PER_FRAME;
    localparam int unsigned SLOTS           = 2;
    localparam int unsigned UNITS           = SLOTS * WORDS_PER_FRAME;
    localparam int unsigned IDX_W           = $clog2(WORDS_PER_FRAME);
    localparam int unsigned SLOT_W          = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned ADDR_W          = $clog2(UNITS);

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [ADDR_W-1:0]  addr_t;

    localparam idx_t  LAST_IDX  = idx_t'(WORDS_PER_FRAME - 1);
    localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);

    // Word-domain walker over the buffer: one unit per word clock
    typedef struct packed {
        logic  run;
        slot_t slot;
        idx_t  idx;
    } wptr_t;

    function automatic idx_t idx_next(input idx_t i);
        return (i == LAST_IDX) ? '0 : i + idx_t'(1);
    endfunction

    function automatic slot_t slot_next(input slot_t s);
        return (s == LAST_SLOT) ? '0 : s + slot_t'(1);
    endfunction

    function automatic addr_t unit_addr(input slot_t s, input idx_t i);
        return addr_t'(int'(s) * WORDS_PER_FRAME + int'(i));
    endfunction

endpackage

// File: rtl/gbx_dpram.sv
// Two-port buffer of UNIT_W-bit units; write and read ports may move
// several adjacent units per access, each port in its own clock.
module gbx_dpram #(
    parameter int unsigned UNIT_W   = 20,
    parameter int unsigned DEPTH    = 12,
    parameter int unsigned WR_UNITS = 1,
    parameter int unsigned RD_UNITS = 1,
    localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       wr_clk,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [WR_UNITS*UNIT_W-1:0] wr_data,
    input  logic                       rd_clk,
    input  logic                       rd_rst,
    input  logic                       rd_en,
    input  logic [AW-1:0]              rd_addr,
    output logic [RD_UNITS*UNIT_W-1:0] rd_data
);

    logic [UNIT_W-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            for (int u = 0; u < int'(WR_UNITS); u++) begin
                mem[AW'(int'(wr_addr) + u)] <= wr_data[u*UNIT_W +: UNIT_W];
            end
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            for (int u = 0; u < int'(RD_UNITS); u++) begin
                rd_data[u*UNIT_W +: UNIT_W] <= mem[AW'(int'(rd_addr) + u)];
            end
        end
    end

endmodule

// File: rtl/gbx_phase.sv
// Frame-phase tracker: a frame-domain toggle seen from the word domain.
// Clocks share one source, so the toggle is compared without synchronizer.
module gbx_phase (
    input  logic clk_frame,
    input  logic rst_frame,
    input  logic clk_word,
    input  logic rst_word,
    output logic boundary_o
);

    logic frm_tgl_q;
    logic seen_tgl_q;

    always_ff @(posedge clk_frame) begin
        if (rst_frame) frm_tgl_q <= 1'b0;
        else           frm_tgl_q <= ~frm_tgl_q;
    end

    always_ff @(posedge clk_word) begin
        if (rst_word) seen_tgl_q <= 1'b0;
        else          seen_tgl_q <= frm_tgl_q;
    end

    // High during the first word period after each frame edge
    assign boundary_o = frm_tgl_q ^ seen_tgl_q;

endmodule

// File: rtl/gbx_word_ptr.sv
// Word-clock walker: restarts at unit 0 on a frame boundary, then steps
// one unit per word clock and moves to the next slot after the last unit.
module gbx_word_ptr
    import gbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  boundary_i,
    output logic  step_o,
    output slot_t slot_o,
    output idx_t  idx_o,
    output logic  run_o,
    output idx_t  cur_idx_o
);

    wptr_t cur_q;
    wptr_t nxt;

    always_comb begin
        nxt    = cur_q;
        step_o = 1'b0;
        if (boundary_i) begin
            step_o   = 1'b1;
            nxt.run  = 1'b1;
            nxt.idx  = '0;
            nxt.slot = cur_q.run ? slot_next(cur_q.slot) : '0;
        end else if (cur_q.run) begin
            step_o   = 1'b1;
            nxt.idx  = idx_next(cur_q.idx);
            nxt.slot = (cur_q.idx == LAST_IDX) ? slot_next(cur_q.slot) : cur_q.slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign slot_o    = nxt.slot;
    assign idx_o     = nxt.idx;
    assign run_o     = cur_q.run;
    assign cur_idx_o = cur_q.idx;

endmodule

// File: rtl/gbx_tx.sv
// Transmit path: wide write per frame clock, narrow read per word clock.
module gbx_tx
    import gbx_pkg::*;
(
    input  logic   clk_frame,
    input  logic   rst_frame,
    input  logic   clk_word,
    input  logic   rst_word,
    input  logic   boundary_i,
    input  frame_t frame_i,
    output word_t  word_o,
    output logic   run_o,
    output idx_t   cur_idx_o
);

    slot_t wr_slot_q;
    logic  rd_step;
    slot_t rd_slot;
    idx_t  rd_idx;

    always_ff @(posedge clk_frame) begin
        if (rst_frame) wr_slot_q <= '0;
        else           wr_slot_q <= slot_next(wr_slot_q);
    end

    gbx_word_ptr u_ptr (
        .clk        (clk_word),
        .rst        (rst_word),
        .boundary_i (boundary_i),
        .step_o     (rd_step),
        .slot_o     (rd_slot),
        .idx_o      (rd_idx),
        .run_o      (run_o),
        .cur_idx_o  (cur_idx_o)
    );

    gbx_dpram #(
        .UNIT_W   (WORD_W),
        .DEPTH    (UNITS),
        .WR_UNITS (WORDS_PER_FRAME),
        .RD_UNITS (1)
    ) u_buf (
        .wr_clk  (clk_frame),
        .wr_en   (~rst_frame),
        .wr_addr (unit_addr(wr_slot_q, '0)),
        .wr_data (frame_i),
        .rd_clk  (clk_word),
        .rd_rst  (rst_word),
        .rd_en   (rd_step),
        .rd_addr (unit_addr(rd_slot, rd_idx)),
        .rd_data (word_o)
    );

endmodule

// File: rtl/gbx_rx.sv
// Receive path: narrow write per word clock, wide read per frame clock.
module gbx_rx
    import gbx_pkg::*;
(
    input  logic   clk_frame,
    input  logic   rst_frame,
    input  logic   clk_word,
    input  logic   rst_word,
    input  logic   boundary_i,
    input  word_t  word_i,
    output frame_t frame_o,
    output logic   valid_o,
    output logic   run_o,
    output idx_t   cur_idx_o
);

    logic  wr_step;
    slot_t wr_slot;
    idx_t  wr_idx;
    logic  grp_tgl_q;
    logic  grp_seen_q;
    logic  grp_new;
    slot_t rd_slot_q;

    gbx_word_ptr u_ptr (
        .clk        (clk_word),
        .rst        (rst_word),
        .boundary_i (boundary_i),
        .step_o     (wr_step),
        .slot_o     (wr_slot),
        .idx_o      (wr_idx),
        .run_o      (run_o),
        .cur_idx_o  (cur_idx_o)
    );

    // Toggles once per completed group of words
    always_ff @(posedge clk_word) begin
        if (rst_word)                              grp_tgl_q <= 1'b0;
        else if (wr_step && (wr_idx == LAST_IDX)) grp_tgl_q <= ~grp_tgl_q;
    end

    always_ff @(posedge clk_frame) begin
        if (rst_frame) begin
            grp_seen_q <= 1'b0;
            rd_slot_q  <= '0;
            valid_o    <= 1'b0;
        end else begin
            grp_seen_q <= grp_tgl_q;
            valid_o    <= grp_new;
            if (grp_new) rd_slot_q <= slot_next(rd_slot_q);
        end
    end

    assign grp_new = grp_tgl_q ^ grp_seen_q;

    gbx_dpram #(
        .UNIT_W   (WORD_W),
        .DEPTH    (UNITS),
        .WR_UNITS (1),
        .RD_UNITS (WORDS_PER_FRAME)
    ) u_buf (
        .wr_clk  (clk_word),
        .wr_en   (wr_step & ~rst_word),
        .wr_addr (unit_addr(wr_slot, wr_idx)),
        .wr_data (word_i),
        .rd_clk  (clk_frame),
        .rd_rst  (rst_frame),
        .rd_en   (grp_new),
        .rd_addr (unit_addr(rd_slot_q, '0)),
        .rd_data (frame_o)
    );

endmodule

// File: rtl/frame_word_gearbox.sv
module frame_word_gearbox
    import gbx_pkg::*;
(
    input  logic               clk_frame_i,
    input  logic               rst_frame_i,
    input  logic               clk_word_i,
    input  logic               rst_word_i,
    input  logic [FRAME_W-1:0] tx_frame_i,
    output logic [WORD_W-1:0]  tx_word_o,
    input  logic [WORD_W-1:0]  rx_word_i,
    output logic [FRAME_W-1:0] rx_frame_o,
    output logic               rx_valid_o
);

    logic boundary_w;
    logic tx_run_w;
    idx_t tx_idx_w;
    logic rx_run_w;
    idx_t rx_idx_w;

    gbx_phase u_phase (
        .clk_frame  (clk_frame_i),
        .rst_frame  (rst_frame_i),
        .clk_word   (clk_word_i),
        .rst_word   (rst_word_i),
        .boundary_o (boundary_w)
    );

    gbx_tx u_tx (
        .clk_frame  (clk_frame_i),
        .rst_frame  (rst_frame_i),
        .clk_word   (clk_word_i),
        .rst_word   (rst_word_i),
        .boundary_i (boundary_w),
        .frame_i    (tx_frame_i),
        .word_o     (tx_word_o),
        .run_o      (tx_run_w),
        .cur_idx_o  (tx_idx_w)
    );

    gbx_rx u_rx (
        .clk_frame  (clk_frame_i),
        .rst_frame  (rst_frame_i),
        .clk_word   (clk_word_i),
        .rst_word   (rst_word_i),
        .boundary_i (boundary_w),
        .word_i     (rx_word_i),
        .frame_o    (rx_frame_o),
        .valid_o    (rx_valid_o),
        .run_o      (rx_run_w),
        .cur_idx_o  (rx_idx_w)
    );

endmodule

// File: rtl/gbx_checker.sv
module gbx_checker
    import gbx_pkg::*;
(
    input logic  clk_frame_i,
    input logic  rst_frame_i,
    input logic  clk_word_i,
    input logic  rst_word_i,
    input word_t tx_word_o,
    input logic  rx_valid_o,
    input logic  boundary_w,
    input logic  tx_run_w,
    input idx_t  tx_idx_w,
    input logic  rx_run_w,
    input idx_t  rx_idx_w
);

    // R1
    tx_idle_zero_chk: assert property (@(posedge clk_word_i) disable iff (rst_word_i)
        !tx_run_w |-> (tx_word_o == '0));

    // R4
    tx_wrap_on_boundary_chk: assert property (@(posedge clk_word_i) disable iff (rst_word_i)
        (boundary_w && tx_run_w) |-> (tx_idx_w == LAST_IDX));

    // R5
    rx_wrap_on_boundary_chk: assert property (@(posedge clk_word_i) disable iff (rst_word_i)
        (boundary_w && rx_run_w) |-> (rx_idx_w == LAST_IDX));

    // R3
    boundary_single_chk: assert property (@(posedge clk_word_i) disable iff (rst_word_i || rst_frame_i)
        boundary_w |=> !boundary_w);

    // R7
    rx_valid_steady_chk: assert property (@(posedge clk_frame_i) disable iff (rst_frame_i || rst_word_i)
        rx_valid_o |=> rx_valid_o);

endmodule

bind frame_word_gearbox gbx_checker u_chk (
    .clk_frame_i (clk_frame_i),
    .rst_frame_i (rst_frame_i),
    .clk_word_i  (clk_word_i),
    .rst_word_i  (rst_word_i),
    .tx_word_o   (tx_word_o),
    .rx_valid_o  (rx_valid_o),
    .boundary_w  (boundary_w),
    .tx_run_w    (tx_run_w),
    .tx_idx_w    (tx_idx_w),
    .rx_run_w    (rx_run_w),
    .rx_idx_w    (rx_idx_w)
);

// File: tb/tb_frame_word_gearbox.sv
module tb_frame_word_gearbox;
    import gbx_pkg::*;

    localparam int WCLK_PERIOD = 10;
    localparam int FRAMES_PER_PHASE = 20;

    logic   clk_frame = 1'b0;
    logic   clk_word  = 1'b0;
    logic   rst_frame = 1'b1;
    logic   rst_word  = 1'b1;
    frame_t tx_frame  = '0;
    word_t  rx_word   = '0;
    word_t  tx_word;
    frame_t rx_frame;
    logic   rx_valid;

    int n_checks = 0;
    int n_fail   = 0;

    frame_t tx_hist[$];
    word_t  rx_hist[$];

    frame_word_gearbox dut (
        .clk_frame_i (clk_frame),
        .rst_frame_i (rst_frame),
        .clk_word_i  (clk_word),
        .rst_word_i  (rst_word),
        .tx_frame_i  (tx_frame),
        .tx_word_o   (tx_word),
        .rx_word_i   (rx_word),
        .rx_frame_o  (rx_frame),
        .rx_valid_o  (rx_valid)
    );

    // Both clocks from one generator; frame edge on every sixth word edge
    initial begin : clkgen
        int k;
        k = 0;
        forever begin
            #(WCLK_PERIOD/2);
            clk_word = 1'b1;
            if (k == 0) clk_frame = 1'b1;
            if (k == 3) clk_frame = 1'b0;
            #(WCLK_PERIOD/2);
            clk_word = 1'b0;
            k = (k + 1) % 6;
        end
    end

    task automatic check_val(input string req, input string what,
                             input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic word_t gen_word(input int m, input int mode);
        case (mode)
            0:       return word_t'($urandom);
            1:       return word_t'(m * 37 + 5);
            default: return (m % 2 == 1) ? word_t'(20'hAAAAA) : word_t'(20'h55555);
        endcase
    endfunction

    function automatic frame_t gen_frame(input int n, input int mode);
        frame_t f;
        for (int j = 0; j < int'(WORDS_PER_FRAME); j++) begin
            case (mode)
                0:       f[j*WORD_W +: WORD_W] = word_t'($urandom);
                1:       f[j*WORD_W +: WORD_W] = word_t'((n << 4) | j);
                default: f[j*WORD_W +: WORD_W] = ((n + j) % 2 == 1) ? '1 : '0;
            endcase
        end
        return f;
    endfunction

    // Sampled after word edge m (counted from reset release)
    task automatic check_edge(input int m);
        int    n;
        word_t exp_w;
        frame_t exp_f;
        string tag;
        if (m == 0) begin
            exp_w = '0;
            tag   = "R1";
        end else begin
            exp_w = tx_hist[(m-1)/6][((m-1)%6)*WORD_W +: WORD_W];
            tag   = (m <= 6) ? "R2 R3" : "R4";
        end
        check_val(tag, "tx_word", FRAME_W'(tx_word), FRAME_W'(exp_w));

        n = m / 6;
        if (n < 2) begin
            check_val("R7", "rx_valid", FRAME_W'(rx_valid), FRAME_W'(1'b0));
        end else begin
            for (int j = 0; j < int'(WORDS_PER_FRAME); j++)
                exp_f[j*WORD_W +: WORD_W] = rx_hist[6*(n-2) + 1 + j];
            check_val("R7", "rx_valid", FRAME_W'(rx_valid), FRAME_W'(1'b1));
            check_val((n == 2) ? "R5 R8" : "R6", "rx_frame", rx_frame, exp_f);
        end
    endtask

    task automatic run_phase(input int mode, input bit restart);
        rst_frame = 1'b1;
        rst_word  = 1'b1;
        repeat (2) @(posedge clk_frame);
        repeat (6) @(negedge clk_word);
        // Still in reset: just before the release frame edge
        check_val(restart ? "R1 R9" : "R1", "reset tx_word", FRAME_W'(tx_word), '0);
        check_val(restart ? "R1 R9" : "R1", "reset rx_valid", FRAME_W'(rx_valid), '0);
        check_val("R1", "reset rx_frame", rx_frame, '0);
        tx_hist.delete();
        rx_hist.delete();
        tx_frame = gen_frame(0, mode);
        tx_hist.push_back(tx_frame);
        rx_word = gen_word(0, mode);
        rx_hist.push_back(rx_word);
        rst_frame = 1'b0;
        rst_word  = 1'b0;
        for (int m = 0; m < FRAMES_PER_PHASE * 6; m++) begin
            @(negedge clk_word);
            check_edge(m);
            if ((m + 1) % 6 == 0) begin
                tx_frame = gen_frame((m + 1) / 6, mode);
                tx_hist.push_back(tx_frame);
            end
            rx_word = gen_word(m + 1, mode);
            rx_hist.push_back(rx_word);
        end
        // Leave mid-frame so the next reset lands inside a frame
        repeat (3) @(negedge clk_word);
    endtask

    initial begin : watchdog
        #(WCLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        run_phase(0, 1'b0);
        run_phase(1, 1'b1);
        run_phase(2, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule